// File: doc/BRIEF.md
# Segment Lookaside Buffer Table

This block is a small, fully associative table that maps effective address segments onto virtual segment descriptors. Each entry holds two 64-bit words. The tag word carries an effective segment identifier and a valid bit. The attribute word carries a two-bit segment-size field in its top bits, along with protection-key, no-execute, large-page and compare bits. The table stores those other bits unchanged and does not interpret them.

A requester issues one operation per cycle with a request/valid strobe:
- an associative lookup by effective address;
- an indexed write with legality checks;
- an indexed read of either word;
- invalidate-all;
- invalidate-by-address.

Each entry matches on either a 256 MB or a 1 TB segment boundary, chosen by its own size field. Results come back registered, one cycle after the request. Illegal operations raise a one-cycle error and leave the table unchanged. Invalidations that actually clear something send a one-cycle flush request to the downstream translation caches.

Word layout:
- The tag word keeps the segment identifier in bits [63:28] and the valid bit at bit 27.
- For a 1 TB entry only bits [63:40] are significant, and bits [39:28] must be zero for it to match.
- In the attribute word, bits [63:62] are the size code: 2'b00 means 256 MB and 2'b01 means 1 TB. Codes 2'b1x are illegal.

Top module: `slb_table`

## Requirements
- R1: After synchronous reset, every entry reads back as zero in both words, no lookup hits, and rsp_err and flush_req are low.
- R2: Lookup (req_op 3'd0) builds two tags from req_addr, each with bit 27 set: {req_addr[63:28], 1, 27'b0} and {req_addr[63:40], 12'b0, 1, 27'b0}. It reports rsp_hit with the entry's words on rsp_tag/rsp_attr when an entry matches.
- R3: An entry matches the 256 MB tag only if its size code is 2'b00, and matches the 1 TB tag only if its size code is 2'b01. An address that agrees with the other form does not hit.
- R4: When several entries match, the lowest-indexed entry is reported.
- R5: Invalidate-all (req_op 3'd4) clears the valid bit of entries 1 and up, never entry 0. It pulses flush_req only if at least one of those entries was valid.
- R6: Invalidate-by-address (req_op 3'd5) clears the valid bit of the lowest matching entry only and pulses flush_req. On a miss it changes nothing and leaves flush_req low.
- R7: Write (req_op 3'd1) takes the slot from req_addr[11:0]. It is refused with rsp_err if that value is 64 or more, and the table is left unchanged.
- R8: A write whose req_data[63:62] is 2'b10 or 2'b11 is refused. A write with 2'b01 is refused while cfg_big_seg_ok is low.
- R9: A legal write stores req_addr with bits [26:0] cleared as the tag word and stores req_data unchanged as the attribute word.
- R10: Read-tag (3'd2) and read-attribute (3'd3) return the slot's word on rsp_word. A slot value in req_addr[11:0] of 64 or more gives rsp_err and a zero word.
- R11: rsp_valid is high exactly in the cycle after each request with op codes 0 to 5. rsp_err, rsp_hit and flush_req last only that cycle. Codes 6 and 7 produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_seg_ok | input | 1 | High when 1 TB segments may be written |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 64 | Effective address, or tag operand with slot in [11:0] |
| req_data | input | 64 | Attribute word for writes |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_err | output | 1 | Illegal operation refused |
| flush_req | output | 1 | Downstream translation cache flush pulse |
| rsp_tag | output | 64 | Tag word of the hit entry |
| rsp_attr | output | 64 | Attribute word of the hit entry |
| rsp_word | output | 64 | Word returned by an indexed read |

## Verification
The response assertions take for granted that req_op and req_valid are stable, known values at each rising edge, and that the requester does not rely on any result in the same cycle it issues a request. The bench meets this by changing inputs only on falling edges. It drops req_valid after every single-cycle request, so each response can be observed in isolation before the next operation. Before each scenario the bench resets the table, so expected contents follow only from the writes that scenario makes. Duplicate tags are written on purpose only where the lowest-index rule is under test.

// File: rtl/slb_pkg.sv
package slb_pkg;

    localparam int WORD_W     = 64;
    localparam int SMALL_BITS = 28;               // 256 MB segment offset width
    localparam int LARGE_BITS = 40;               // 1 TB segment offset width
    localparam int VALID_POS  = SMALL_BITS - 1;   // valid bit sits just below segment ID
    localparam int SLOT_W     = 12;               // slot field width in the operand
    localparam int SIZE_HI    = WORD_W - 1;
    localparam int SIZE_LO    = WORD_W - 2;

    localparam logic [1:0] SZ_SMALL = 2'b00;
    localparam logic [1:0] SZ_LARGE = 2'b01;

    typedef enum logic [2:0] {
        OP_LOOKUP   = 3'd0,
        OP_WRITE    = 3'd1,
        OP_RD_TAG   = 3'd2,
        OP_RD_ATTR  = 3'd3,
        OP_INV_ALL  = 3'd4,
        OP_INV_ADDR = 3'd5
    } slb_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] tag;
        logic [WORD_W-1:0] attr;
    } slb_entry_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              err;
        logic              flush;
        logic [WORD_W-1:0] tag;
        logic [WORD_W-1:0] attr;
        logic [WORD_W-1:0] word;
    } slb_rsp_t;

    // Tag compared against entries sized for 256 MB segments.
    function automatic logic [WORD_W-1:0] tag_small(input logic [WORD_W-1:0] ea);
        logic [WORD_W-1:0] t;
        t = {ea[WORD_W-1:SMALL_BITS], {SMALL_BITS{1'b0}}};
        t[VALID_POS] = 1'b1;
        return t;
    endfunction

    // Tag compared against entries sized for 1 TB segments.
    function automatic logic [WORD_W-1:0] tag_large(input logic [WORD_W-1:0] ea);
        logic [WORD_W-1:0] t;
        t = {ea[WORD_W-1:LARGE_BITS], {LARGE_BITS{1'b0}}};
        t[VALID_POS] = 1'b1;
        return t;
    endfunction

    // Stored tag keeps segment ID and valid bit; slot number and reserved bits drop.
    function automatic logic [WORD_W-1:0] tag_keep(input logic [WORD_W-1:0] op);
        return {op[WORD_W-1:VALID_POS], {VALID_POS{1'b0}}};
    endfunction

    function automatic logic [1:0] size_of(input logic [WORD_W-1:0] attr);
        return attr[SIZE_HI:SIZE_LO];
    endfunction

endpackage

// File: rtl/slb_wr_check.sv
module slb_wr_check
    import slb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic [SLOT_W-1:0] slot_field,
    input  logic [1:0]        size_code,
    input  logic              big_ok,
    output logic              slot_ok,
    output logic              write_ok
);
    localparam int IDXW = $clog2(ENTRIES);

    logic size_ok;

    // Any bit at or above the table size inside the slot field is illegal.
    assign slot_ok  = (slot_field[SLOT_W-1:IDXW] == '0);
    assign size_ok  = (size_code == SZ_SMALL) || ((size_code == SZ_LARGE) && big_ok);
    assign write_ok = slot_ok && size_ok;

    always_comb begin
        if (write_ok) begin
            AST_WR_SIZE_LEGAL: assert (size_code[1] == 1'b0); // R8
        end
    end

endmodule

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  slb_entry_t                 tbl [ENTRIES],
    input  logic [WORD_W-1:0]          ea,
    output logic [ENTRIES-1:0]         hit_vec,
    output logic                       hit,
    output logic [$clog2(ENTRIES)-1:0] hit_idx
);
    localparam int IDXW = $clog2(ENTRIES);

    logic [WORD_W-1:0] t_small;
    logic [WORD_W-1:0] t_large;

    assign t_small = tag_small(ea);
    assign t_large = tag_large(ea);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic sm_hit;
        logic lg_hit;
        assign sm_hit = (tbl[g].tag == t_small) && (size_of(tbl[g].attr) == SZ_SMALL);
        assign lg_hit = (tbl[g].tag == t_large) && (size_of(tbl[g].attr) == SZ_LARGE);
        assign hit_vec[g] = sm_hit || lg_hit;
    end

    // Lowest index wins: scan downward so the smallest hit is written last.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDXW'(i);
        end
    end

    assign hit = |hit_vec;

    always_comb begin
        if (hit) begin
            AST_HIT_ENTRY_VALID: assert (tbl[hit_idx].tag[VALID_POS] == 1'b1); // R2
        end
    end

endmodule

// File: rtl/slb_table.sv
module slb_table
    import slb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_big_seg_ok,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [63:0]       req_addr,
    input  logic [63:0]       req_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic              flush_req,
    output logic [63:0]       rsp_tag,
    output logic [63:0]       rsp_attr,
    output logic [63:0]       rsp_word
);
    localparam int IDXW = $clog2(ENTRIES);

    slb_entry_t          tbl [ENTRIES];
    slb_rsp_t            rsp_q;
    slb_op_e             op;
    logic                op_known;

    logic [ENTRIES-1:0]  m_vec;
    logic                m_hit;
    logic [IDXW-1:0]     m_idx;
    logic                slot_ok;
    logic                write_ok;
    logic [IDXW-1:0]     slot;
    logic [ENTRIES-1:0]  valid_vec;

    assign op       = slb_op_e'(req_op);
    assign op_known = (req_op <= 3'd5);
    assign slot     = req_addr[IDXW-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = tbl[g].tag[VALID_POS];
    end

    slb_match #(.ENTRIES(ENTRIES)) u_match (
        .tbl     (tbl),
        .ea      (req_addr),
        .hit_vec (m_vec),
        .hit     (m_hit),
        .hit_idx (m_idx)
    );

    slb_wr_check #(.ENTRIES(ENTRIES)) u_chk (
        .slot_field (req_addr[SLOT_W-1:0]),
        .size_code  (size_of(req_data)),
        .big_ok     (cfg_big_seg_ok),
        .slot_ok    (slot_ok),
        .write_ok   (write_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl[i] <= '0;
            end
            rsp_q <= '0;
        end else begin
            rsp_q       <= '0;
            rsp_q.valid <= req_valid && op_known;
            if (req_valid) begin
                case (op)
                    OP_LOOKUP: begin
                        rsp_q.hit <= m_hit;
                        if (m_hit) begin
                            rsp_q.tag  <= tbl[m_idx].tag;
                            rsp_q.attr <= tbl[m_idx].attr;
                        end
                    end
                    OP_WRITE: begin
                        if (write_ok) begin
                            tbl[slot].tag  <= tag_keep(req_addr);
                            tbl[slot].attr <= req_data;
                        end else begin
                            rsp_q.err <= 1'b1;
                        end
                    end
                    OP_RD_TAG: begin
                        if (slot_ok) rsp_q.word <= tbl[slot].tag;
                        else         rsp_q.err  <= 1'b1;
                    end
                    OP_RD_ATTR: begin
                        if (slot_ok) rsp_q.word <= tbl[slot].attr;
                        else         rsp_q.err  <= 1'b1;
                    end
                    OP_INV_ALL: begin
                        for (int i = 1; i < ENTRIES; i++) begin
                            tbl[i].tag[VALID_POS] <= 1'b0;
                        end
                        rsp_q.flush <= |valid_vec[ENTRIES-1:1];
                    end
                    OP_INV_ADDR: begin
                        if (m_hit) tbl[m_idx].tag[VALID_POS] <= 1'b0;
                        rsp_q.flush <= m_hit;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_err   = rsp_q.err;
    assign flush_req = rsp_q.flush;
    assign rsp_tag   = rsp_q.tag;
    assign rsp_attr  = rsp_q.attr;
    assign rsp_word  = rsp_q.word;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && (req_op <= 3'd5) && !rst)); // R11

    AST_HIT_FROM_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> $past(req_valid && req_op == 3'd0)); // R2

    AST_FLUSH_FROM_INV: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(req_valid && (req_op == 3'd4 || req_op == 3'd5))); // R5

    AST_ERR_FROM_INDEXED: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $past(req_valid && req_op >= 3'd1 && req_op <= 3'd3)); // R7

    AST_BAD_SIZE_REFUSED: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_op == 3'd1 && req_data[63] && !rst) |-> rsp_err); // R8

    AST_ENTRY0_KEPT: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_op == 3'd4 && !rst) |-> (tbl[0] == $past(tbl[0]))); // R5

endmodule

// File: tb/tb_slb_table.sv
module tb_slb_table;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_big_seg_ok;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [63:0] req_addr;
    logic [63:0] req_data;
    logic        rsp_valid, rsp_hit, rsp_err, flush_req;
    logic [63:0] rsp_tag, rsp_attr, rsp_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [63:0] VB = 64'h1 << 27;

    always #4 clk = ~clk;

    slb_table dut (
        .clk(clk), .rst(rst), .cfg_big_seg_ok(cfg_big_seg_ok),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .flush_req(flush_req), .rsp_tag(rsp_tag),
        .rsp_attr(rsp_attr), .rsp_word(rsp_word)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
        cfg_big_seg_ok = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Issue one request; outputs are sampled at the following falling edge.
    task automatic do_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [63:0] seg_s(input logic [35:0] s);
        return {s, 28'h0};
    endfunction

    function automatic logic [63:0] seg_l(input logic [23:0] s);
        return {s, 40'h0};
    endfunction

    function automatic logic [63:0] attr(input logic [1:0] sz, input logic [61:0] rest);
        return {sz, rest};
    endfunction

    task automatic t_reset();
        do_reset();
        do_op(3'd0, 64'h0, '0);
        check("R1 lookup miss after reset", rsp_hit, 0);
        check("R1 no err after reset", rsp_err, 0);
        check("R1 no flush after reset", flush_req, 0);
        do_op(3'd2, 64'd63, '0);
        check("R1 slot63 tag zero", rsp_word, 0);
        do_op(3'd3, 64'd0, '0);
        check("R1 slot0 attr zero", rsp_word, 0);
    endtask

    task automatic t_write_read();
        do_reset();
        do_op(3'd1, seg_s(36'h123456789) | VB | 64'h5A5_003, attr(2'b00, 62'h1234_abcd));
        check("R9 write ok", rsp_err, 0);
        do_op(3'd2, 64'd3, '0);
        check("R9 tag masked", rsp_word, seg_s(36'h123456789) | VB);
        check("R10 read valid", rsp_valid, 1);
        do_op(3'd3, 64'd3, '0);
        check("R9 attr unchanged", rsp_word, attr(2'b00, 62'h1234_abcd));
        do_op(3'd2, 64'd64, '0);
        check("R10 read slot 64 err", rsp_err, 1);
        check("R10 read err word zero", rsp_word, 0);
        @(negedge clk);
        check("R11 err one cycle", rsp_err, 0);
        check("R11 valid one cycle", rsp_valid, 0);
        do_op(3'd3, 64'hFFF, '0);
        check("R10 read attr slot FFF err", rsp_err, 1);
    endtask

    task automatic t_lookup_sizes();
        do_reset();
        do_op(3'd1, seg_s(36'h0ABCDEF01) | VB | 64'd4, attr(2'b00, 62'h44));
        do_op(3'd0, seg_s(36'h0ABCDEF01) | 64'h0FF_FFFF, '0);
        check("R2 small hit", rsp_hit, 1);
        check("R2 small hit tag", rsp_tag, seg_s(36'h0ABCDEF01) | VB);
        check("R2 small hit attr", rsp_attr, attr(2'b00, 62'h44));
        do_op(3'd0, seg_s(36'h0ABCDEF02), '0);
        check("R2 neighbour segment miss", rsp_hit, 0);
        do_op(3'd1, seg_l(24'hC0FFEE) | VB | 64'd5, attr(2'b01, 62'h55));
        do_op(3'd0, seg_l(24'hC0FFEE) | 64'h12_3456_7890, '0);
        check("R3 large hit", rsp_hit, 1);
        check("R3 large hit attr", rsp_attr, attr(2'b01, 62'h55));
        // small-sized entry whose tag equals a large-form tag
        do_op(3'd1, seg_l(24'h00BEEF) | VB | 64'd7, attr(2'b00, 62'h77));
        do_op(3'd0, seg_l(24'h00BEEF) | (64'h1 << 30), '0);
        check("R3 small entry ignores large tag", rsp_hit, 0);
        do_op(3'd0, seg_l(24'h00BEEF), '0);
        check("R3 small entry exact small tag hits", rsp_attr, attr(2'b00, 62'h77));
        do_op(3'd6, 64'h0, '0);
        check("R11 op 6 no response", rsp_valid, 0);
    endtask

    task automatic t_priority_inv_addr();
        do_reset();
        do_op(3'd1, seg_s(36'h777) | VB | 64'd20, attr(2'b00, 62'h20));
        do_op(3'd1, seg_s(36'h777) | VB | 64'd10, attr(2'b00, 62'h10));
        do_op(3'd1, seg_s(36'h888) | VB | 64'd30, attr(2'b00, 62'h30));
        do_op(3'd0, seg_s(36'h777), '0);
        check("R4 lowest index wins", rsp_attr, attr(2'b00, 62'h10));
        do_op(3'd5, seg_s(36'h777) | 64'h10, '0);
        check("R6 inv addr flush", flush_req, 1);
        do_op(3'd2, 64'd10, '0);
        check("R6 slot10 cleared", rsp_word, seg_s(36'h777));
        do_op(3'd2, 64'd20, '0);
        check("R6 slot20 kept", rsp_word, seg_s(36'h777) | VB);
        do_op(3'd0, seg_s(36'h777), '0);
        check("R6 next match now slot20", rsp_attr, attr(2'b00, 62'h20));
        do_op(3'd5, seg_s(36'h999), '0);
        check("R6 miss no flush", flush_req, 0);
        do_op(3'd0, seg_s(36'h888), '0);
        check("R6 miss leaves others", rsp_hit, 1);
    endtask

    task automatic t_illegal_write();
        do_reset();
        do_op(3'd1, seg_s(36'h111) | VB | 64'd0, attr(2'b00, 62'h1));
        do_op(3'd1, seg_s(36'h222) | VB | 64'd64, attr(2'b00, 62'h2));
        check("R7 slot 64 refused", rsp_err, 1);
        do_op(3'd2, 64'd0, '0);
        check("R7 slot0 unchanged", rsp_word, seg_s(36'h111) | VB);
        do_op(3'd1, seg_s(36'h222) | VB | 64'hFC1, attr(2'b00, 62'h2));
        check("R7 slot FC1 refused", rsp_err, 1);
        do_op(3'd1, seg_s(36'h333) | VB | 64'd9, attr(2'b10, 62'h3));
        check("R8 size 10 refused", rsp_err, 1);
        do_op(3'd3, 64'd9, '0);
        check("R8 slot9 attr unchanged", rsp_word, 0);
        cfg_big_seg_ok = 1'b0;
        do_op(3'd1, seg_l(24'h44) | VB | 64'd9, attr(2'b01, 62'h4));
        check("R8 large refused when unsupported", rsp_err, 1);
        do_op(3'd0, seg_l(24'h44), '0);
        check("R8 refused large not stored", rsp_hit, 0);
        cfg_big_seg_ok = 1'b1;
        do_op(3'd1, seg_l(24'h44) | VB | 64'd9, attr(2'b01, 62'h4));
        check("R8 large accepted when supported", rsp_err, 0);
    endtask

    task automatic t_inv_all();
        do_reset();
        do_op(3'd1, seg_s(36'hA0) | VB | 64'd0, attr(2'b00, 62'hA0));
        do_op(3'd1, seg_s(36'hA1) | VB | 64'd1, attr(2'b00, 62'hA1));
        do_op(3'd1, seg_s(36'hA2) | VB | 64'd63, attr(2'b00, 62'hA2));
        do_op(3'd4, 64'h0, '0);
        check("R5 inv all flush", flush_req, 1);
        do_op(3'd0, seg_s(36'hA0), '0);
        check("R5 entry0 survives", rsp_hit, 1);
        do_op(3'd0, seg_s(36'hA2), '0);
        check("R5 entry63 cleared", rsp_hit, 0);
        do_op(3'd2, 64'd1, '0);
        check("R5 entry1 valid bit clear", rsp_word, seg_s(36'hA1));
        do_op(3'd4, 64'h0, '0);
        check("R5 no flush when only entry0 valid", flush_req, 0);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_lookup_sizes();
        t_priority_inv_addr();
        t_illegal_write();
        t_inv_all();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual running expected finished");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule